// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is the target end of a two-wire serial byte memory that is read from the bus. It oversamples the clock and data lines with the system clock and recognises START, STOP and repeated START. It returns array bytes through an open-drain data output, modelled as an enable that pulls the line low. A byte pointer is held across transactions and serves three kinds of read:
- a plain read at the current pointer;
- a read at an address that a preceding dummy write has loaded;
- a burst, in which the bus controller keeps acknowledging bytes and the target keeps sending.

The pointer always names the byte after the last one accessed. It wraps from the top of the array to zero, also in the middle of a burst. The array holds 2^ADDR_W bytes, so ADDR_W = 15 gives a 32768-byte part. It is filled through a side write port, and the bus never writes it.

Top module: `tw_mem_reader`

## Requirements
- R1: After reset, sda_oe is 0 and the byte pointer is 0, so the first current-address read returns the byte at address 0.
- R2: On a device address byte whose upper 7 bits equal DEV_ID and whose lowest bit (R/W) is 1, the target pulls SDA low in the acknowledge bit. It then sends the byte at the pointer, most significant bit first.
- R3: On a device address byte whose upper 7 bits differ from DEV_ID, there is no acknowledge, SDA is never pulled low, and the pointer is left unchanged until the next START or STOP.
- R4: A dummy write is a matching device address with R/W = 0, followed by a high address byte and then a low address byte. The target acknowledges each of the three bytes and loads the pointer with the low ADDR_W bits of {high, low}, so higher bits of the high byte are ignored. When a STOP follows at once, the next current-address read returns the byte at the loaded address.
- R5: A repeated START after a dummy write, followed by a matching device address with R/W = 1, returns the byte at the loaded address.
- R6: Each byte sent advances the pointer by one, and the pointer keeps its value across transactions.
- R7: When the controller acknowledges a byte (SDA low in the 9th bit), the next sequential byte follows. When it does not (SDA high), the target releases SDA and keeps it released until START or STOP.
- R8: The pointer wraps from 2^ADDR_W-1 to 0, also inside a burst, and the byte at address 0 is sent next.
- R9: sda_oe changes only while SCL is low. It is 0 during the controller's acknowledge bit and after a STOP.
- R10: A side write (bd_we high for one clock) stores bd_data at bd_addr, and a later bus read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| bd_we | input | 1 | Side write strobe into the array |
| bd_addr | input | ADDR_W | Side write address |
| bd_data | input | 8 | Side write data |

## Verification
The bench builds the block with ADDR_W = 9 and DEV_ID = 7'h52. The 512-byte array then puts the wrap from 0x1FF to 0 within reach of a short four-byte burst. With a 9-bit address, bit 0 of the high address byte is live and bits 7..1 of that byte are ignored, so one random read with 0xFF as the high byte checks both the masking and the live bit. The device ID is not the common default, and the bench sends a neighbouring ID to show that a mismatch is rejected.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_ACK, S_HOLD, S_TX, S_MACK, S_IGN
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic rise_s,
  output logic fall_s,
  output logic start_s,
  output logic stop_s
);
  logic scl_m, scl_p, sda_m, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign rise_s  = scl_s & ~scl_p;
  assign fall_s  = ~scl_s & scl_p;
  assign start_s = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_s  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_byte_mem.sv
module tw_byte_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tw_mem_reader.sv
module tw_mem_reader
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h50,
  parameter int         ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              bd_we,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [7:0]        bd_data
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic scl_s, sda_s, rise_s, fall_s, start_s, stop_s;
  tw_state_e st, nxt;
  logic [3:0] cnt;
  logic [7:0] rx, hi, tx, mem_q;
  logic [ADDR_W-1:0] ptr;
  logic [15:0] addr_full;
  logic mack, ld_addr;

  tw_bus_sense u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .rise_s(rise_s), .fall_s(fall_s),
    .start_s(start_s), .stop_s(stop_s)
  );

  tw_byte_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(bd_we), .waddr(bd_addr), .wdata(bd_data),
    .raddr(ptr), .rdata(mem_q)
  );

  assign addr_full = {hi, rx};
  assign ld_addr = (st == S_ALO) && fall_s && (cnt == 4'd8) && !start_s && !stop_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; rx <= '0; hi <= '0;
      tx <= '0; ptr <= '0; sda_oe <= 1'b0; mack <= 1'b0;
    end else if (start_s) begin
      st <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_s) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO: begin
          if (rise_s) begin
            rx  <= {rx[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (fall_s && cnt == 4'd8) begin
            cnt <= '0;
            if (st == S_DEV) begin
              if (rx[7:1] == DEV_ID) begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
                nxt    <= rx[0] ? S_TX : S_AHI;
              end else begin
                st <= S_IGN;
              end
            end else if (st == S_AHI) begin
              hi <= rx; sda_oe <= 1'b1; st <= S_ACK; nxt <= S_ALO;
            end else begin
              ptr <= addr_full[ADDR_W-1:0];
              sda_oe <= 1'b1; st <= S_ACK; nxt <= S_HOLD;
            end
          end
        end
        S_ACK: if (fall_s) begin
          if (nxt == S_TX) begin
            tx <= mem_q; sda_oe <= ~mem_q[7]; ptr <= ptr + ONE;
          end else begin
            sda_oe <= 1'b0;
          end
          st <= nxt; cnt <= '0;
        end
        S_TX: if (fall_s) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0; st <= S_MACK;
          end else begin
            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
          end
        end
        S_MACK: begin
          if (rise_s) mack <= ~sda_s;
          else if (fall_s) begin
            cnt <= '0;
            if (mack) begin
              tx <= mem_q; sda_oe <= ~mem_q[7]; ptr <= ptr + ONE; st <= S_TX;
            end else begin
              st <= S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_mem_reader_chk.sv
module tw_mem_reader_chk
  import tw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_s,
  input logic              stop_s,
  input logic              sda_oe,
  input tw_state_e         st,
  input logic [ADDR_W-1:0] ptr,
  input logic              ld_addr
);
  // R9: output enable moves only in the SCL low phase
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) && !$past(start_s) && !$past(stop_s) |-> !scl_s);

  // R9: released once a STOP has been seen
  a_r9_release_stop: assert property (@(posedge clk) disable iff (rst)
    stop_s |=> !sda_oe);

  // R7: released while the controller owns the acknowledge bit
  a_r7_free_mack: assert property (@(posedge clk) disable iff (rst)
    (st == S_MACK) |-> !sda_oe);

  // R3: ignored bus is never pulled low
  a_r3_ign_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_IGN) && $past(st == S_IGN) |-> !sda_oe);

  // R6 / R8: pointer only steps by one (modulo) unless loaded
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) && !$past(ld_addr) |-> ptr == ADDR_W'($past(ptr) + 1));

  // R1: idle target does not drive
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) && $past(st == S_IDLE) |-> !sda_oe);
endmodule

bind tw_mem_reader tw_mem_reader_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_s(start_s), .stop_s(stop_s),
  .sda_oe(sda_oe), .st(st), .ptr(ptr), .ld_addr(ld_addr)
);

// File: tb/tw_mem_reader_tb_top.sv
module tw_mem_reader_tb_top;
  localparam int         AW    = 9;
  localparam int         DEPTH = 1 << AW;
  localparam logic [6:0] ID    = 7'h52;
  localparam int         Q     = 5;
  localparam int         H     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;

  logic [7:0] model [DEPTH];
  int bptr = 0;
  int n_chk = 0;
  int n_err = 0;
  int scl_hi_moves = 0;
  int ack_drive = 0;
  bit oe_seen = 1'b0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = ~(m_low | sda_oe);

  tw_mem_reader #(.DEV_ID(ID), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  always @(negedge clk) begin
    if (!rst && sda_oe != prev_oe && scl_m) scl_hi_moves++;
    if (sda_oe) oe_seen = 1'b1;
    prev_oe = sda_oe;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bd_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = AW'(a); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
    model[a] = d;
  endtask

  task automatic bus_start();
    w(Q); m_low = 1'b0; w(Q); scl_m = 1'b1; w(H); m_low = 1'b1; w(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(Q); m_low = 1'b1; w(Q); scl_m = 1'b1; w(H); m_low = 1'b0; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_low = ~b[i]; w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0;
    end
    w(Q); m_low = 1'b0; w(Q); scl_m = 1'b1; w(Q); ack = ~sda_line; w(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(Q); w(Q); scl_m = 1'b1; w(Q); d[i] = sda_line; w(Q); scl_m = 1'b0;
    end
    w(Q); m_low = give_ack; w(Q); scl_m = 1'b1; w(Q);
    if (sda_oe) ack_drive++;
    w(Q); scl_m = 1'b0; w(Q); m_low = 1'b0;
  endtask

  task automatic exp_next(input string tag, input logic [7:0] got);
    chk(tag, got, model[bptr]);
    bptr = (bptr + 1) % DEPTH;
  endtask

  task automatic t_current(input string tag);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte({ID, 1'b1}, ack);
    chk("R2 dev ack", 8'(ack), 8'd1);
    recv_byte(1'b0, d);
    exp_next(tag, d);
    bus_stop();
  endtask

  task automatic set_addr(input logic [7:0] ah, input logic [7:0] al);
    logic ack;
    bus_start();
    send_byte({ID, 1'b0}, ack); chk("R4 wr dev ack", 8'(ack), 8'd1);
    send_byte(ah, ack);         chk("R4 hi ack", 8'(ack), 8'd1);
    send_byte(al, ack);         chk("R4 lo ack", 8'(ack), 8'd1);
    bptr = int'({ah, al}) % DEPTH;
  endtask

  task automatic t_random(input logic [7:0] ah, input logic [7:0] al, input string tag);
    logic ack; logic [7:0] d;
    set_addr(ah, al);
    bus_start();
    send_byte({ID, 1'b1}, ack); chk("R5 rd dev ack", 8'(ack), 8'd1);
    recv_byte(1'b0, d);
    exp_next(tag, d);
    bus_stop();
  endtask

  task automatic t_dummy_stop();
    set_addr(8'hFE, 8'h33);
    bus_stop();
    t_current("R4 read after dummy write");
    t_current("R6 pointer persists");
  endtask

  task automatic t_burst_wrap();
    logic ack; logic [7:0] d;
    set_addr(8'h01, 8'hFE);
    bus_start();
    send_byte({ID, 1'b1}, ack); chk("R7 burst dev ack", 8'(ack), 8'd1);
    recv_byte(1'b1, d); exp_next("R7 burst byte0", d);
    recv_byte(1'b1, d); exp_next("R8 burst top byte", d);
    recv_byte(1'b1, d); exp_next("R8 wrapped to zero", d);
    recv_byte(1'b0, d); exp_next("R7 burst last", d);
    oe_seen = 1'b0;
    for (int i = 0; i < 2; i++) begin
      w(Q); scl_m = 1'b1; w(H); scl_m = 1'b0; w(Q);
    end
    chk("R7 released after nack", 8'(oe_seen), 8'd0);
    bus_stop();
    t_current("R8 pointer after wrap");
  endtask

  task automatic t_mismatch();
    logic ack; logic [7:0] d;
    bus_start();
    oe_seen = 1'b0;
    send_byte({ID ^ 7'h01, 1'b1}, ack);
    chk("R3 no ack", 8'(ack), 8'd0);
    recv_byte(1'b0, d);
    chk("R3 bus idle high", d, 8'hFF);
    chk("R3 never driven", 8'(oe_seen), 8'd0);
    bus_stop();
    t_current("R3 pointer untouched");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'((i * 37 + 5) ^ (i >> 1));
    end
    w(4);
    chk("R1 reset oe", 8'(sda_oe), 8'd0);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) bd_write(i, model[i]);
    w(4);
    chk("R1 idle oe", 8'(sda_oe), 8'd0);
    t_current("R1 first read at zero");
    t_current("R6 second read advances");
    t_random(8'hFF, 8'hA5, "R5 random read masked hi");
    t_current("R6 follows random read");
    t_dummy_stop();
    t_burst_wrap();
    t_mismatch();
    bd_write(16, 8'h5C);
    t_random(8'h00, 8'h10, "R10 side write visible");
    chk("R9 oe moved with SCL high", 8'(scl_hi_moves), 8'd0);
    chk("R9 driven in controller ack", 8'(ack_drive), 8'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule